// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns one host request into one complete NAND flash bus cycle: a command latch cycle, an address latch cycle, or a plain data cycle that writes or reads. It drives the chip enable, the two latch enables, the write and read strobes, the data output enable and the data bus. It also captures the byte or halfword the flash returns on a read. A host agent presents a request with a valid/ready handshake. One request is one cycle, so a multi-byte address is issued as successive address requests, one byte each, in the order the host presents them.

Every cycle runs through four programmed phases. A setup phase raises chip enable and the latch enables. A wait phase holds the active strobe low. A hold phase keeps the data valid with the strobe high. A turnaround phase releases the bus. Two extra delays keep a read strobe away from the end of a command cycle and from the end of an address cycle. A mode field enables the bank, selects the NAND device type, sets the bus width, turns on gating by the ready/busy pin, and holds a synchronous bank reset.

Top module: `nand_strobe_seq`

## Requirements
- R1: `req_kind` 0 gives a command cycle (CLE high) and 1 gives an address cycle (ALE high); these two are always writes and ignore `req_read`. Kind 2 or 3 gives a data cycle with both latch enables low. CE# is low and the latch enable is valid for the whole setup, wait and hold span.
- R2: Timing word bits 7:0 give the setup length, bits 15:8 the wait length and bits 23:16 the hold length, each in clocks. A field value of 0 gives 1 clock.
- R3: Timing word bits 31:24 give the number of turnaround clocks after hold, with CE# high; 0 skips the phase. If a write request is already pending, CE# stays high for exactly turnaround+1 clocks between two cycles.
- R4: In a write cycle, WE# is low for the wait phase only. `nand_dq_oe` is high from setup through hold, and `nand_dq_out` carries the request data. In a read cycle, RE# is low for the wait phase and `nand_dq_oe` stays low. WE# and RE# are never low together.
- R5: A read samples `nand_dq_in` on the last clock of the wait phase. `rsp_valid` is high for exactly one clock, the first hold clock, with the sampled value on `rsp_rdata`.
- R6: A data read that follows a command cycle waits `cfg_cle_re` extra idle clocks before it starts. One that follows an address cycle waits `cfg_ale_re` extra idle clocks. Writes never wait on these delays.
- R7: `cfg_mode[4]` selects a 16-bit bus. When it is clear, bits 15:8 of `nand_dq_out` and of `rsp_rdata` are zero. `bus_wide` mirrors the bit.
- R8: When `cfg_mode[1]` is set, no cycle starts while `nand_rb` is low. When it is clear, `nand_rb` has no effect.
- R9: While bank enable `cfg_mode[2]` or NAND type `cfg_mode[3]` is clear, `req_ready` is low and no cycle starts.
- R10: Setting bank reset `cfg_mode[0]` aborts any cycle. From the next clock all strobes are inactive, and `req_ready` stays low while the bit is set.
- R11: `req_ready` is high only between cycles, so exactly one cycle runs per accepted request, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 5 | bit0 bank reset, bit1 ready gating, bit2 bank enable, bit3 NAND type, bit4 wide bus |
| cfg_cle_re | input | 4 | Extra idle clocks before a read that follows a command cycle |
| cfg_ale_re | input | 4 | Extra idle clocks before a read that follows an address cycle |
| cfg_timing | input | 32 | Packed phase lengths: setup, wait, hold, turnaround |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock if valid |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_read | input | 1 | Data cycle direction, 1 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus sampled value |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| bus_wide | output | 1 | Active bus width is 16 bits |

## Verification
The bench targets the zero-valued timing fields, the turnaround gap between back-to-back cycles, and the read delays after command and address cycles. A design that did not round zero fields up to one clock would give strobes of no width. An off-by-one in a counter would show up as a measured phase or gap that is one clock wrong. The bench also checks narrow-bus masking, ready/busy gating in both settings, the enable and device-type gating, and a bank reset during a strobe. A design that got one of these wrong would leave a wrong upper byte on the bus, start a cycle against a busy flash, or keep a strobe low after the abort.

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq #(
  parameter int DW = 16,
  parameter int PW = 8,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    cfg_mode,
  input  logic [GW-1:0] cfg_cle_re,
  input  logic [GW-1:0] cfg_ale_re,
  input  logic [4*PW-1:0] cfg_timing,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_read,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_in,
  input  logic          nand_rb,
  output logic          bus_wide
);
  localparam int HW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WAIT, S_HOLD, S_HIZ} phase_t;

  phase_t        st;
  logic [PW-1:0] cnt;
  logic [GW-1:0] gap;
  logic [1:0]    kind_q;
  logic          rd_q;
  logic [DW-1:0] wd_q;

  wire [PW-1:0] t_setup = cfg_timing[PW-1:0];
  wire [PW-1:0] t_wait  = cfg_timing[2*PW-1:PW];
  wire [PW-1:0] t_hold  = cfg_timing[3*PW-1:2*PW];
  wire [PW-1:0] t_hiz   = cfg_timing[4*PW-1:3*PW];

  wire bank_rst = cfg_mode[0];
  wire rb_ok    = !cfg_mode[1] || nand_rb;
  wire usable   = cfg_mode[2] && cfg_mode[3] && !bank_rst;
  wire [DW-1:0] dmask = cfg_mode[4] ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};

  wire want_rd = req_kind[1] && req_read;
  assign req_ready = (st == S_IDLE) && usable && rb_ok && (!want_rd || gap == '0);
  wire accept = req_valid && req_ready;

  wire [GW-1:0] gap_next = (kind_q == 2'd0) ? cfg_cle_re :
                           (kind_q == 2'd1) ? cfg_ale_re : '0;

  function automatic logic [PW-1:0] span(input logic [PW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      gap       <= '0;
      kind_q    <= 2'd2;
      rd_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (bank_rst) begin
      st        <= S_IDLE;
      gap       <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (gap != '0) gap <= gap - 1'b1;
          if (accept) begin
            st     <= S_SETUP;
            cnt    <= span(t_setup);
            kind_q <= req_kind;
            rd_q   <= want_rd;
            wd_q   <= req_wdata;
          end
        end
        S_SETUP:
          if (cnt == '0) begin
            st  <= S_WAIT;
            cnt <= span(t_wait);
          end else cnt <= cnt - 1'b1;
        S_WAIT:
          if (cnt == '0) begin
            st  <= S_HOLD;
            cnt <= span(t_hold);
            if (rd_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= nand_dq_in & dmask;
            end
          end else cnt <= cnt - 1'b1;
        S_HOLD:
          if (cnt == '0) begin
            if (t_hiz != '0) begin
              st  <= S_HIZ;
              cnt <= t_hiz - 1'b1;
            end else begin
              st  <= S_IDLE;
              gap <= gap_next;
            end
          end else cnt <= cnt - 1'b1;
        S_HIZ:
          if (cnt == '0) begin
            st  <= S_IDLE;
            gap <= gap_next;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire active = (st == S_SETUP) || (st == S_WAIT) || (st == S_HOLD);

  assign nand_ce_n   = !active;
  assign nand_cle    = active && (kind_q == 2'd0);
  assign nand_ale    = active && (kind_q == 2'd1);
  assign nand_we_n   = !((st == S_WAIT) && !rd_q);
  assign nand_re_n   = !((st == S_WAIT) && rd_q);
  assign nand_dq_oe  = active && !rd_q;
  assign nand_dq_out = wd_q & dmask;
  assign bus_wide    = cfg_mode[4];
endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] cfg_mode,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe,
  input logic       nand_rb
);
  assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_drive_in_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n || nand_cle || nand_ale) |-> !nand_ce_n);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_oe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> (nand_re_n && !nand_ce_n));
  assert_rsp_after_re_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!nand_re_n));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_ce_n && cfg_mode[1] && !nand_rb) |=> nand_ce_n);
  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_ce_n && !cfg_mode[2]) |=> nand_ce_n);
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[0] |=> nand_ce_n);
  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);
endmodule

bind nand_strobe_seq nand_strobe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_dq_oe(nand_dq_oe), .nand_rb(nand_rb)
);

// File: tb/test_nand_strobe_seq.sv
module test_nand_strobe_seq;
  logic clk = 0, rst_n = 0;
  logic [4:0] cfg_mode = '0;
  logic [3:0] cfg_cle_re = '0, cfg_ale_re = '0;
  logic [31:0] cfg_timing = '0;
  logic req_valid = 0, req_read = 0, nand_rb = 1;
  logic [1:0] req_kind = '0;
  logic [15:0] req_wdata = '0, rd_model = '0;
  logic req_ready, rsp_valid, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, bus_wide;
  logic [15:0] rsp_rdata, nand_dq_out;

  always #10 clk = ~clk;

  nand_strobe_seq i_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cle_re(cfg_cle_re),
    .cfg_ale_re(cfg_ale_re), .cfg_timing(cfg_timing), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_read(req_read),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(rd_model), .nand_rb(nand_rb),
    .bus_wide(bus_wide));

  typedef struct packed {
    logic [1:0] kind; logic rd; logic [15:0] data;
    int s; int w; int h; int gap;
  } cyc_t;

  cyc_t exp_q[$];
  logic [15:0] rsp_q[$];
  int errors = 0, checks = 0;
  bit mon_off = 0, done = 0;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // driver: pushes the expected cycle, then runs the handshake
  task automatic issue(input logic [1:0] k, input logic rd, input logic [15:0] d, input int gap);
    cyc_t e;
    e.kind = k; e.rd = rd; e.gap = gap;
    e.data = bus_wide ? d : {8'h00, d[7:0]};
    e.s = eff(int'(cfg_timing[7:0]));
    e.w = eff(int'(cfg_timing[15:8]));
    e.h = eff(int'(cfg_timing[23:16]));
    if (!mon_off) exp_q.push_back(e);
    if (rd && !mon_off) rsp_q.push_back(bus_wide ? rd_model : {8'h00, rd_model[7:0]});
    @(negedge clk);
    req_kind = k; req_read = rd; req_wdata = d; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: rebuilds each cycle from the pins and compares with the queue
  bit in_cyc = 0, seen = 0, o_cle, o_ale, o_rd;
  int s_c, w_c, h_c, hi_cnt = 1000, gap_obs;
  logic [15:0] o_data;
  always @(negedge clk) begin
    if (mon_off) begin
      in_cyc = 0; hi_cnt = 0;
    end else if (!nand_ce_n) begin
      if (!in_cyc) begin
        in_cyc = 1; seen = 0; s_c = 0; w_c = 0; h_c = 0; gap_obs = hi_cnt;
        o_cle = nand_cle; o_ale = nand_ale; o_rd = 0; o_data = '0;
      end
      if (!nand_we_n || !nand_re_n) begin
        w_c++; seen = 1;
        if (!nand_re_n) o_rd = 1;
        if (!nand_we_n) o_data = nand_dq_out;
      end else if (!seen) s_c++;
      else h_c++;
    end else begin
      if (in_cyc) begin
        cyc_t e;
        in_cyc = 0; hi_cnt = 1;
        if (exp_q.size() == 0) chk(0, "R11", "unexpected cycle", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(o_cle == (e.kind == 2'd0) && o_ale == (e.kind == 2'd1), "R1", "latch enables",
              {o_cle, o_ale}, {e.kind == 2'd0, e.kind == 2'd1});
          chk(o_rd == e.rd, "R4", "strobe direction", o_rd, e.rd);
          if (!e.rd) chk(o_data == e.data, "R4/R7", "write data", o_data, e.data);
          chk(s_c == e.s, "R2", "setup clocks", s_c, e.s);
          chk(w_c == e.w, "R2", "wait clocks", w_c, e.w);
          chk(h_c == e.h, "R2", "hold clocks", h_c, e.h);
          if (e.gap >= 0) chk(gap_obs == e.gap, "R3/R6", "CE high gap", gap_obs, e.gap);
        end
      end else hi_cnt++;
    end
    if (rsp_valid) begin
      logic [15:0] x;
      if (rsp_q.size() == 0) chk(0, "R5", "unexpected response", 1, 0);
      else begin
        x = rsp_q.pop_front();
        chk(rsp_rdata == x, "R5/R7", "read data", rsp_rdata, x);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "ALL", "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !rsp_valid && !req_ready,
        "R9", "reset state", 0, 0);
    rst_n = 1;

    // wide bus, general timing: setup 2, wait 3, hold 1, turnaround 2
    cfg_mode = 5'b11110; cfg_cle_re = 4'd3; cfg_ale_re = 4'd5;
    cfg_timing = {8'd2, 8'd1, 8'd3, 8'd2};
    @(negedge clk);
    chk(bus_wide == 1'b1, "R7", "bus_wide set", bus_wide, 1);
    issue(2'd0, 0, 16'h0090, -1);
    issue(2'd1, 0, 16'h0012, 3);              // R3 turnaround 2 + 1
    issue(2'd1, 0, 16'h0034, 3);              // R11 address bytes in order
    rd_model = 16'hBEEF;
    issue(2'd2, 1, 16'h0000, 2 + 5 + 1);      // R6 read after address
    issue(2'd2, 0, 16'h5A5A, 3);              // R6 writes do not wait
    issue(2'd0, 0, 16'h0070, 3);
    rd_model = 16'hC3A5;
    issue(2'd2, 1, 16'h0000, 2 + 3 + 1);      // R6 read after command
    drain();

    // zero-valued fields: all phases 1 clock, no turnaround (R2, R3)
    cfg_timing = 32'h0;
    issue(2'd0, 0, 16'h00FF, -1);
    rd_model = 16'h0F0F;
    issue(2'd2, 1, 16'h0000, 0 + 3 + 1);
    issue(2'd2, 0, 16'h1111, 1);
    drain();

    // narrow bus, zero read delays (R7, R6)
    cfg_mode = 5'b01110; cfg_cle_re = 0; cfg_ale_re = 0;
    cfg_timing = {8'd1, 8'd3, 8'd2, 8'd1};
    @(negedge clk);
    chk(bus_wide == 1'b0, "R7", "bus_wide clear", bus_wide, 0);
    issue(2'd0, 0, 16'h0005, -1);
    rd_model = 16'h1234;
    issue(2'd2, 1, 16'h0000, 2);
    issue(2'd2, 0, 16'hABCD, 2);
    drain();

    // long phases
    cfg_mode = 5'b11110;
    cfg_timing = {8'd5, 8'd10, 8'd30, 8'd20};
    issue(2'd2, 0, 16'h7E81, -1);
    issue(2'd3, 0, 16'h0102, 6);
    drain();
    cfg_timing = {8'd2, 8'd1, 8'd3, 8'd2};

    // R9: disabled bank, then NAND type clear
    for (int pass = 0; pass < 2; pass++) begin
      bit quiet = 1;
      cfg_mode = (pass == 0) ? 5'b11010 : 5'b10110;
      fork issue(2'd2, 0, 16'h2468, -1); join_none
      repeat (10) begin
        @(negedge clk);
        if (!nand_ce_n || req_ready) quiet = 0;
      end
      chk(quiet, "R9", "request ignored while gated", !quiet, 0);
      cfg_mode = 5'b11110;
      drain();
    end

    // R8: ready gating on, flash busy
    begin
      bit quiet = 1;
      nand_rb = 0;
      fork issue(2'd2, 0, 16'h3355, -1); join_none
      repeat (8) begin
        @(negedge clk);
        if (!nand_ce_n) quiet = 0;
      end
      chk(quiet, "R8", "held while busy", !quiet, 0);
      nand_rb = 1;
      drain();
    end
    // R8: gating off, busy ignored
    cfg_mode = 5'b11100; nand_rb = 0;
    issue(2'd0, 0, 16'h00AA, -1);
    drain();
    nand_rb = 1; cfg_mode = 5'b11110;

    // R10: bank reset during the write strobe
    mon_off = 1;
    fork issue(2'd2, 0, 16'h9999, -1); join_none
    @(negedge clk);
    while (nand_we_n) @(negedge clk);
    cfg_mode = 5'b11111;
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && !nand_dq_oe && !nand_cle && !nand_ale, "R10", "strobes after abort",
        {nand_ce_n, nand_we_n, nand_dq_oe}, 3'b110);
    repeat (3) @(negedge clk);
    chk(!req_ready && nand_ce_n, "R10", "ready low during bank reset", req_ready, 0);
    cfg_mode = 5'b11110;
    @(negedge clk);
    mon_off = 0;
    rd_model = 16'h6006;
    issue(2'd2, 1, 16'h0000, -1);
    drain();

    chk(exp_q.size() == 0 && rsp_q.size() == 0, "R11", "all cycles seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule